// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous on-chip requester and an external asynchronous static RAM of 128K bytes. The memory has a 17-bit address, a bidirectional 8-bit data bus, an active-low and an active-high chip select, and active-low write and output strobes. The controller takes one request at a time over a valid/ready handshake. It drives the memory pins from its own state. It returns read data with a single-cycle valid strobe.

Every phase length is a cycle count. Each count is derived at elaboration from a clock period parameter and the memory's nanosecond limits, rounded up. A write keeps the output strobe high for its whole length. During a write, the data-bus drivers stay off until the memory has had time to release the bus. A level power-down request, taken only from idle, parks the memory deselected in a data-retention state. When the request drops, the controller holds off all accesses for a recovery interval.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, req_ready_o is 1, rsp_valid_o is 0, ret_o is 0, mem_ce1_no is 1, mem_ce2_o is 0, mem_we_no is 1, mem_oe_no is 1 and mem_dq_oe_o is 0.
- R2: Pin encoding depends on the phase. When idle, the memory is deselected with mem_ce1_no=1 and mem_ce2_o=0, and both strobes are high. During a read phase the pins are mem_ce1_no=0, mem_ce2_o=1, mem_we_no=1 and mem_oe_no=0.
- R3: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. After a read is accepted, req_ready_o is 0 for RD_CYC cycles (4 at a 20 ns clock). rsp_valid_o is then 1 for exactly one cycle, the fifth cycle after acceptance, carrying the byte sampled on the last read cycle.
- R4: After a write is accepted, the memory is selected and mem_we_no is 0 for exactly WR_CYC consecutive cycles (4 at a 20 ns clock). mem_oe_no stays 1 throughout, and req_ready_o is 0 for those cycles.
- R5: Within a write, mem_dq_oe_o stays 0 for the first TA_CYC cycles of mem_we_no low (2 at a 20 ns clock). It is then 1 for the remaining WR_CYC-TA_CYC cycles, with mem_dq_o equal to the request's write byte. It is never 1 while mem_we_no is 1, and never 1 while the memory may drive the bus.
- R6: A read of any address from 0x00000 to 0x1FFFF returns the byte most recently written there.
- R7: If pd_req_i is 1 while the controller is idle, it enters retention on the next edge. ret_o goes to 1, mem_ce1_no to 1 and mem_ce2_o to 0. req_ready_o stays 0 and no request is accepted until recovery ends.
- R8: After pd_req_i returns to 0 in retention, req_ready_o stays 0 for exactly RECOV_CYC further cycles (100 with the bench's 2000 ns recovery at 20 ns). It then returns to 1.
- R9: A power-down request that arrives during an access takes effect only after the access completes. In idle, a power-down request takes precedence over a request presented in the same cycle.
- R10: Memory contents survive a retention period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read-data strobe |
| rsp_rdata_o | output | 8 | Read byte |
| pd_req_i | input | 1 | Level request for data retention |
| ret_o | output | 1 | Memory held in retention state |
| mem_addr_o | output | 17 | Memory address pins |
| mem_ce1_no | output | 1 | Memory chip select, active low |
| mem_ce2_o | output | 1 | Memory chip select, active high |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_oe_no | output | 1 | Memory output strobe, active low |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe_o | output | 1 | Enable of the data-bus drivers |
| mem_dq_i | input | 8 | Data received from memory |

## Verification
The assertions assume that requests, the power-down level and the memory's returned byte are synchronous to the clock and settled away from the rising edge. They also assume that the memory answers only while selected for a read. The bench changes every input on the falling edge. Its memory model presents read data only when the pins encode a read, and records write data only while the write strobe overlaps the drivers. The model also flags any cycle in which the controller and the memory could drive the bus together.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RET,
    ST_RECOV
  } state_e;

  // round a nanosecond limit up to whole clock cycles
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_ctrl.sv
module sram_pin_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WR_CYC = 4,
  parameter int unsigned TA_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  state_e           state_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ce1_no,
  output logic             ce2_o,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);

  // counter runs WR_CYC-1 .. 0; drivers on once TA_CYC cycles elapsed
  localparam logic [CNT_W-1:0] DRV_FROM = CNT_W'(WR_CYC - 1 - TA_CYC);

  logic sel;

  always_comb begin
    sel     = (state_i == ST_READ) || (state_i == ST_WRITE);
    ce1_no  = !sel;
    ce2_o   = sel;
    we_no   = (state_i != ST_WRITE);
    oe_no   = (state_i != ST_READ);
    dq_oe_o = (state_i == ST_WRITE) && (cnt_i <= DRV_FROM);
  end

  // R4
  wr_oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);

  // R5
  drv_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!we_no && oe_no && !ce1_no && ce2_o));

  // R5
  drv_turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TA_CYC > 0 && $rose(dq_oe_o)) |-> $past(!we_no));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned T_RC     = 70,
  parameter int unsigned T_AA     = 70,
  parameter int unsigned T_DOE    = 35,
  parameter int unsigned T_WC     = 70,
  parameter int unsigned T_PWE    = 50,
  parameter int unsigned T_AW     = 60,
  parameter int unsigned T_SCE    = 60,
  parameter int unsigned T_SD     = 30,
  parameter int unsigned T_HZ     = 25,
  parameter int unsigned RECOV_NS = 5000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              pd_req_i,
  output logic              ret_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned TA_CYC  = ns2cyc(T_HZ, CLK_NS);
  localparam int unsigned RD_CYC  = umax(1, umax(ns2cyc(T_RC, CLK_NS),
                                    umax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_DOE, CLK_NS))));
  localparam int unsigned WR_CYC  = umax(TA_CYC + umax(1, ns2cyc(T_SD, CLK_NS)),
                                    umax(ns2cyc(T_WC, CLK_NS), umax(ns2cyc(T_PWE, CLK_NS),
                                    umax(ns2cyc(T_AW, CLK_NS), ns2cyc(T_SCE, CLK_NS)))));
  localparam int unsigned REC_CYC = ns2cyc(RECOV_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(REC_CYC, umax(RD_CYC, WR_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  state_e            state_q, state_d;
  logic              ld;
  logic [CNT_W-1:0]  ld_val, cnt;
  logic              cnt_zero, accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  assign req_ready_o = (state_q == ST_IDLE) && !pd_req_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (pd_req_i) begin
          state_d = ST_RET;
        end else if (req_valid_i) begin
          state_d = req_we_i ? ST_WRITE : ST_READ;
          ld      = 1'b1;
          ld_val  = req_we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ, ST_WRITE, ST_RECOV: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_RET: begin
        if (!pd_req_i) begin
          if (REC_CYC == 0) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RECOV;
            ld      = 1'b1;
            ld_val  = CNT_W'(REC_CYC - 1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      // sample on last read cycle
      if (state_q == ST_READ && cnt_zero) begin
        rdata_q <= mem_dq_i;
        rsp_q   <= 1'b1;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  sram_pin_ctrl #(.CNT_W(CNT_W), .WR_CYC(WR_CYC), .TA_CYC(TA_CYC)) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_q),
    .cnt_i   (cnt),
    .ce1_no  (mem_ce1_no),
    .ce2_o   (mem_ce2_o),
    .we_no   (mem_we_no),
    .oe_no   (mem_oe_no),
    .dq_oe_o (mem_dq_oe_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign ret_o       = (state_q == ST_RET);

  // R3
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R7
  ret_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |-> (mem_ce1_no && !mem_ce2_o && mem_we_no && !req_ready_o));

  // R9
  pd_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_req_i && req_ready_o) |-> 1'b0);

endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  localparam int TA = 2;
  localparam int RD = 4;
  localparam int WR = 4;
  localparam int RECOV = 100;

  // {we, addr[16:0], data[7:0]}; for reads data is the expected byte
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'h3C}, {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0AAAA, 8'h5A}, {1'b1, 17'h15555, 8'hA5},
    {1'b0, 17'h00000, 8'h3C}, {1'b0, 17'h1FFFF, 8'hC3},
    {1'b0, 17'h0AAAA, 8'h5A}, {1'b0, 17'h15555, 8'hA5},
    {1'b1, 17'h00000, 8'hFF}, {1'b0, 17'h00000, 8'hFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [16:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        pd_req_i = 1'b0;
  logic [7:0]  mem_dq_i = '0;
  logic        req_ready_o, rsp_valid_o, ret_o;
  logic [7:0]  rsp_rdata_o, mem_dq_o;
  logic [16:0] mem_addr_o;
  logic        mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_dq_oe_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  sram_ctrl #(.CLK_NS(20), .RECOV_NS(2000)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i,
    .req_wdata_i, .rsp_valid_o, .rsp_rdata_o, .pd_req_i, .ret_o, .mem_addr_o,
    .mem_ce1_no, .mem_ce2_o, .mem_we_no, .mem_oe_no, .mem_dq_o, .mem_dq_oe_o,
    .mem_dq_i
  );

  // memory model and write-phase monitor
  logic [7:0]  mem_model [int];
  int          we_run = 0, drv_run = 0, last_we = 0, last_drv = 0, contention = 0;
  bit          early = 0, oebad = 0, last_early = 0, last_oebad = 0, prev_we = 1;
  logic [7:0]  wdat = '0, last_wdat = '0;
  logic [16:0] waddr = '0;

  always @(negedge clk_i) begin
    automatic bit rd_en = !mem_ce1_no && mem_ce2_o && mem_we_no && !mem_oe_no;
    if (!mem_we_no) begin
      we_run++;
      waddr = mem_addr_o;
      if (!mem_oe_no) oebad = 1;
      if (mem_dq_oe_o) begin
        drv_run++;
        wdat = mem_dq_o;
        if (we_run <= TA) early = 1;
      end
    end else if (!prev_we) begin
      if (drv_run > 0) mem_model[int'(waddr)] = wdat;
      last_we = we_run; last_drv = drv_run; last_early = early;
      last_oebad = oebad; last_wdat = wdat;
      we_run = 0; drv_run = 0; early = 0; oebad = 0;
    end
    prev_we = mem_we_no;
    if (mem_dq_oe_o && rd_en) contention++;
    if (rd_en) mem_dq_i = mem_model.exists(int'(mem_addr_o)) ? mem_model[int'(mem_addr_o)] : 8'h00;
    else       mem_dq_i = 8'h00;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [16:0] addr, input logic [7:0] data,
                        input bit pd_after, output logic [7:0] rd,
                        output int low_cnt, output int rsp_at, output bit rd_pins_ok);
    bit seen_hi = 0;
    @(negedge clk_i);
    for (int k = 0; k < 200 && !req_ready_o; k++) @(negedge clk_i);
    req_valid_i = 1; req_we_i = we; req_addr_i = addr; req_wdata_i = data;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    if (pd_after) pd_req_i = 1;
    rd_pins_ok = !mem_ce1_no && mem_ce2_o && mem_we_no && !mem_oe_no;
    low_cnt = 0; rsp_at = 0; rd = '0;
    for (int k = 1; k <= 8; k++) begin
      if (k > 1) @(negedge clk_i);
      if (req_ready_o) seen_hi = 1;
      else if (!seen_hi) low_cnt++;
      if (rsp_valid_o && rsp_at == 0) begin rsp_at = k; rd = rsp_rdata_o; end
    end
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lowc, rat, n;
    bit pins_ok;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !ret_o, "R1 handshake in reset", {req_ready_o, rsp_valid_o, ret_o}, 3'b100);
    chk(mem_ce1_no && !mem_ce2_o && mem_we_no && mem_oe_no && !mem_dq_oe_o, "R1 pins in reset",
        {mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no, mem_dq_oe_o}, 5'b10110);
    rst_ni = 1;
    @(negedge clk_i);
    // R2 idle encoding
    chk(mem_ce1_no && !mem_ce2_o && mem_we_no && mem_oe_no, "R2 idle pins",
        {mem_ce1_no, mem_ce2_o, mem_we_no, mem_oe_no}, 4'b1011);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 0, rd, lowc, rat, pins_ok);
      if (VEC[i][25]) begin
        chk(lowc == WR, "R4 busy cycles on write", lowc, WR);
        chk(last_we == WR, "R4 write strobe width", last_we, WR);
        chk(!last_oebad, "R4 output strobe high in write", last_oebad, 0);
        chk(last_drv == WR - TA, "R5 driven cycles", last_drv, WR - TA);
        chk(!last_early, "R5 turnaround", last_early, 0);
        chk(last_wdat == VEC[i][7:0], "R5 write byte on bus", last_wdat, VEC[i][7:0]);
      end else begin
        chk(pins_ok, "R2 read pins", pins_ok, 1);
        chk(lowc == RD, "R3 busy cycles on read", lowc, RD);
        chk(rat == RD + 1, "R3 response cycle", rat, RD + 1);
        chk(rd == VEC[i][7:0], "R6 read data", rd, VEC[i][7:0]);
      end
    end

    // R7 retention entry and blocking
    @(negedge clk_i);
    pd_req_i = 1;
    @(negedge clk_i);
    chk(ret_o && mem_ce1_no && !mem_ce2_o && !req_ready_o, "R7 retention pins",
        {ret_o, mem_ce1_no, mem_ce2_o, req_ready_o}, 4'b1100);
    req_valid_i = 1; req_we_i = 1; req_addr_i = 17'h0AAAA; req_wdata_i = 8'h11;
    n = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      if (!mem_we_no || !mem_oe_no || req_ready_o) n++;
    end
    chk(n == 0, "R7 request ignored in retention", n, 0);
    req_valid_i = 0;
    pd_req_i = 0;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      if (req_ready_o) break;
      n++;
    end
    chk(n == RECOV, "R8 recovery hold-off", n, RECOV);
    access(0, 17'h0AAAA, 8'h00, 0, rd, lowc, rat, pins_ok);
    chk(rd == 8'h5A, "R10 data kept through retention", rd, 8'h5A);

    // R9 power-down during a read
    access(0, 17'h1FFFF, 8'h00, 1, rd, lowc, rat, pins_ok);
    chk(rat == RD + 1 && rd == 8'hC3, "R9 read completes before retention", rd, 8'hC3);
    chk(ret_o, "R9 retention after access", ret_o, 1);
    pd_req_i = 0;
    for (int k = 0; k < 300 && !req_ready_o; k++) @(negedge clk_i);

    // R9 power-down beats a simultaneous request
    @(negedge clk_i);
    pd_req_i = 1; req_valid_i = 1; req_we_i = 1; req_addr_i = 17'h00000; req_wdata_i = 8'h77;
    @(negedge clk_i);
    chk(ret_o && mem_we_no, "R9 power-down wins in idle", {ret_o, mem_we_no}, 2'b11);
    req_valid_i = 0; pd_req_i = 0;
    for (int k = 0; k < 300 && !req_ready_o; k++) @(negedge clk_i);
    access(0, 17'h00000, 8'h00, 0, rd, lowc, rat, pins_ok);
    chk(rd == 8'hFF, "R9 rejected write left memory unchanged", rd, 8'hFF);

    chk(contention == 0, "R5 no bus contention", contention, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule